// File: doc/BRIEF.md
# Oversampled UART Receive Deserializer

This block turns an asynchronous serial line into parallel characters. It is paced by a clock-enable pulse that the surrounding logic produces at either 16 or 8 times the baud rate. The mode input picks which rate applies. The serial input is first synchronized. A falling edge seen while the receiver is idle starts a tick counter. Half a bit period later the line is checked again, and a start bit that has already returned high is dropped as noise. After a valid start bit, each data bit, the optional parity bit and the stop bit are each sampled once, at the centre of its own bit period.

Every character comes out as a right-aligned byte with four status flags: parity error, framing error, break and overrun. A single-cycle write strobe goes with it, meant for a holding register or a receive FIFO. The overrun flag records the full indication that the downstream store gives at the moment the character completes. Word length and parity selection come from static configuration inputs, which change only while the line is idle.

Top module: `uart_rx_deser`

## Requirements
- R1: While reset is asserted and on the first cycle after reset, `rx_valid` is 0, and `rx_data` and all four error flags are 0.
- R2: With `os_mode_8x`=0, a bit period is 16 `os_tick` pulses, and a well-formed character is delivered with its exact data bits.
- R3: With `os_mode_8x`=1, a bit period is 8 `os_tick` pulses, and a well-formed character is delivered with its exact data bits.
- R4: A low pulse that is back high at the mid-start-bit sample (8 ticks in 16X mode, 4 ticks in 8X mode after the edge) produces no character, and a normal character that follows is still received.
- R5: `word_len` values 00, 01, 10 and 11 select 5, 6, 7 and 8 data bits. Bits arrive least significant first, and bits of `rx_data` above the word length are 0.
- R6: With `par_en`=1, one parity bit follows the data. `par_odd`=0 expects an even number of ones over data and parity, and `par_odd`=1 expects an odd number. A mismatch sets `err_parity`. With `par_en`=0, `err_parity` is always 0.
- R7: `err_frame` is 1 exactly when the stop-bit sample is low.
- R8: `err_break` is 1 exactly when every data sample, the parity sample (if enabled) and the stop sample are low. A break therefore also reports `err_frame`=1 and `rx_data`=0.
- R9: `err_overrun` equals the value of `hold_full` in the cycle of the stop-bit sample.
- R10: `rx_valid` is a one-cycle pulse, raised once per accepted character in the cycle after the stop-bit sample. `rx_data` and the flags hold their values until the next character.
- R11: After the stop-bit sample the receiver is idle at once, so characters sent back to back with no gap after the stop bit are all received in order.
- R12: A new character needs a falling edge. A line that stays low after a break produces no further characters until it has gone high and then low again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| os_tick | input | 1 | Oversampling clock enable, one pulse per oversample period |
| os_mode_8x | input | 1 | 0 = 16 ticks per bit, 1 = 8 ticks per bit |
| word_len | input | 2 | Data bits: 00=5, 01=6, 10=7, 11=8 |
| par_en | input | 1 | 1 = a parity bit follows the data |
| par_odd | input | 1 | 0 = even parity, 1 = odd parity |
| hold_full | input | 1 | Downstream store full; captured as overrun |
| rx_serial | input | 1 | Asynchronous serial line, idle high |
| rx_valid | output | 1 | One-cycle write strobe for a new character |
| rx_data | output | 8 | Received character, right-aligned |
| err_parity | output | 1 | Parity mismatch on this character |
| err_frame | output | 1 | Stop bit sampled low |
| err_break | output | 1 | All samples of the character low |
| err_overrun | output | 1 | Store was full when the character completed |

## Verification
Directed frames in both oversampling modes separate the 16-tick timing from the 8-tick timing. A frame read with the wrong bit period would decode with shifted or wrong bits. Short low glitches in each mode test start validation against a receiver that would accept any edge. All-ones data at each word length shows whether the bit count and the zeroing of the upper bits are right. Correct and deliberately flipped parity in both senses, a low stop bit, an all-zero break followed by a line held low, and back-to-back frames separate the flag logic and the return-to-idle timing. Random frames across modes, lengths, parity settings, stop values and `hold_full` are then compared against expected values that bench functions compute.

// File: rtl/uart_rx_pkg.sv
// Package: shared types for the oversampled serial receiver.
// Holds the receiver state encoding, the per-character status record and
// the word-length decode used by the frame controller and the bench-facing top.
package uart_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_PAR   = 3'd3,
        ST_STOP  = 3'd4
    } rx_state_e;

    typedef struct packed {
        logic overrun;
        logic brk;
        logic frame;
        logic parity;
    } rx_err_t;

    // Number of data bits selected by the 2-bit length field (5..8).
    function automatic logic [3:0] data_bits(input logic [1:0] len_sel);
        return 4'd5 + {2'b00, len_sel};
    endfunction

endpackage

// File: rtl/rx_line_sync.sv
// Module: rx_line_sync
// Brings the asynchronous serial line into the clock domain through a
// chain of STAGES flops and flags a high-to-low transition of the
// synchronized line. Assumes the line idles high; all flops reset high
// so that reset release never looks like a falling edge.
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_async,
    output logic line_sync,
    output logic line_fall
);

    logic [STAGES-1:0] chain;
    logic              prev_q;

    // Synchronizer chain: stage 0 captures the raw line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain[0] <= line_async;
        end
    end

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_stage
            // Each later stage copies the one before it.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain[g] <= 1'b1;
                end else begin
                    chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    // Previous synchronized value, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
        end else begin
            prev_q <= chain[STAGES-1];
        end
    end

    assign line_sync = chain[STAGES-1];
    assign line_fall = prev_q & ~chain[STAGES-1];

endmodule

// File: rtl/rx_bit_timer.sv
// Module: rx_bit_timer
// Counts oversampling ticks and emits a sample strobe at bit centres.
// After a restart the first strobe comes half a bit period later (start-bit
// centre); each later strobe comes one full bit period after the previous.
// Assumes OS_HI and OS_LO are even and OS_HI >= OS_LO.
module rx_bit_timer #(
    parameter int OS_HI = 16,
    parameter int OS_LO = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic mode_lo,
    input  logic restart,
    input  logic run,
    output logic sample
);

    localparam int CNT_W = $clog2(OS_HI);
    localparam int LIM_W = CNT_W + 1;
    localparam logic [LIM_W-1:0] HALF_HI = LIM_W'(OS_HI / 2);
    localparam logic [LIM_W-1:0] HALF_LO = LIM_W'(OS_LO / 2);
    localparam logic [LIM_W-1:0] FULL_HI = LIM_W'(OS_HI);
    localparam logic [LIM_W-1:0] FULL_LO = LIM_W'(OS_LO);

    logic [CNT_W-1:0] cnt_q;
    logic             first_q;
    logic [LIM_W-1:0] limit;

    // Select the tick count to the next sample point.
    always_comb begin
        if (first_q) begin
            limit = mode_lo ? HALF_LO : HALF_HI;
        end else begin
            limit = mode_lo ? FULL_LO : FULL_HI;
        end
    end

    assign sample = run & tick & ({1'b0, cnt_q} == (limit - LIM_W'(1)));

    // Tick counter; cleared at each sample and on restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            first_q <= 1'b1;
        end else if (restart) begin
            cnt_q   <= '0;
            first_q <= 1'b1;
        end else if (sample) begin
            cnt_q   <= '0;
            first_q <= 1'b0;
        end else if (run && tick) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/rx_frame_ctrl.sv
// Module: rx_frame_ctrl
// Frame sequencer and assembler. Walks start, data, optional parity and
// stop bits on the timer's sample strobes, validates the start bit,
// assembles data LSB first, and publishes the character with its status.
// Assumes word_len, par_en and par_odd are stable while a frame is in flight.
module rx_frame_ctrl
    import uart_rx_pkg::*;
#(
    parameter int DATA_MAX = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                line,
    input  logic                line_fall,
    input  logic                sample,
    input  logic [1:0]          word_len,
    input  logic                par_en,
    input  logic                par_odd,
    input  logic                hold_full,
    output logic                timer_restart,
    output logic                timer_run,
    output logic                valid_o,
    output logic [DATA_MAX-1:0] data_o,
    output rx_err_t             err_o
);

    localparam int IDX_W = $clog2(DATA_MAX);
    localparam int NB_W  = IDX_W + 1;

    rx_state_e           state_q;
    logic [IDX_W-1:0]    idx_q;
    logic [DATA_MAX-1:0] shreg_q;
    logic                par_acc_q;
    logic                all_low_q;
    logic                par_err_q;
    logic [NB_W-1:0]     last_idx;
    logic                last_data;

    assign last_idx      = NB_W'(data_bits(word_len)) - NB_W'(1);
    assign last_data     = ({1'b0, idx_q} == last_idx);
    assign timer_restart = (state_q == ST_IDLE) & line_fall;
    assign timer_run     = (state_q != ST_IDLE);

    // State sequencing on edges and sample strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (line_fall) state_q <= ST_START;
                ST_START: if (sample)    state_q <= line ? ST_IDLE : ST_DATA;
                ST_DATA:  if (sample && last_data) state_q <= par_en ? ST_PAR : ST_STOP;
                ST_PAR:   if (sample)    state_q <= ST_STOP;
                ST_STOP:  if (sample)    state_q <= ST_IDLE;
                default:                 state_q <= ST_IDLE;
            endcase
        end
    end

    // Data assembly and running parity / all-low tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q     <= '0;
            shreg_q   <= '0;
            par_acc_q <= 1'b0;
            all_low_q <= 1'b1;
            par_err_q <= 1'b0;
        end else if (sample) begin
            case (state_q)
                ST_START: begin
                    idx_q     <= '0;
                    shreg_q   <= '0;
                    par_acc_q <= 1'b0;
                    all_low_q <= 1'b1;
                    par_err_q <= 1'b0;
                end
                ST_DATA: begin
                    shreg_q[idx_q] <= line;
                    par_acc_q      <= par_acc_q ^ line;
                    all_low_q      <= all_low_q & ~line;
                    idx_q          <= idx_q + IDX_W'(1);
                end
                ST_PAR: begin
                    par_err_q <= (line != (par_acc_q ^ par_odd));
                    all_low_q <= all_low_q & ~line;
                end
                default: ;
            endcase
        end
    end

    // Character publication at the stop-bit sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            data_o  <= '0;
            err_o   <= '0;
        end else begin
            valid_o <= 1'b0;
            if (sample && state_q == ST_STOP) begin
                valid_o       <= 1'b1;
                data_o        <= shreg_q;
                err_o.parity  <= par_err_q;
                err_o.frame   <= ~line;
                err_o.brk     <= all_low_q & ~line;
                err_o.overrun <= hold_full;
            end
        end
    end

endmodule

// File: rtl/uart_rx_deser.sv
// Module: uart_rx_deser (top)
// Oversampled serial receive deserializer: synchronizer and edge detect,
// bit-centre timer, and frame sequencer. Produces one character with status
// flags and a one-cycle strobe per accepted frame.
// Assumes os_tick is a single-cycle enable at 16x or 8x the baud rate and
// that configuration inputs change only while the line is idle.
module uart_rx_deser
    import uart_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int OS_HI       = 16,
    parameter int OS_LO       = 8,
    parameter int DATA_MAX    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                os_tick,
    input  logic                os_mode_8x,
    input  logic [1:0]          word_len,
    input  logic                par_en,
    input  logic                par_odd,
    input  logic                hold_full,
    input  logic                rx_serial,
    output logic                rx_valid,
    output logic [DATA_MAX-1:0] rx_data,
    output logic                err_parity,
    output logic                err_frame,
    output logic                err_break,
    output logic                err_overrun
);

    logic    line_s;
    logic    line_fall;
    logic    smp;
    logic    t_restart;
    logic    t_run;
    rx_err_t err_w;

    rx_line_sync #(
        .STAGES(SYNC_STAGES)
    ) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_async(rx_serial),
        .line_sync (line_s),
        .line_fall (line_fall)
    );

    rx_bit_timer #(
        .OS_HI(OS_HI),
        .OS_LO(OS_LO)
    ) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (os_tick),
        .mode_lo(os_mode_8x),
        .restart(t_restart),
        .run    (t_run),
        .sample (smp)
    );

    rx_frame_ctrl #(
        .DATA_MAX(DATA_MAX)
    ) ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .line         (line_s),
        .line_fall    (line_fall),
        .sample       (smp),
        .word_len     (word_len),
        .par_en       (par_en),
        .par_odd      (par_odd),
        .hold_full    (hold_full),
        .timer_restart(t_restart),
        .timer_run    (t_run),
        .valid_o      (rx_valid),
        .data_o       (rx_data),
        .err_o        (err_w)
    );

    assign err_parity  = err_w.parity;
    assign err_frame   = err_w.frame;
    assign err_break   = err_w.brk;
    assign err_overrun = err_w.overrun;

endmodule

// File: rtl/uart_rx_deser_chk.sv
// Module: uart_rx_deser_chk
// Property checker bound to uart_rx_deser. Watches only top-level ports.
// Assumes configuration inputs are stable across each frame.
module uart_rx_deser_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       hold_full,
    input logic [1:0] word_len,
    input logic       par_en,
    input logic       rx_valid,
    input logic [7:0] rx_data,
    input logic       err_parity,
    input logic       err_frame,
    input logic       err_break,
    input logic       err_overrun
);

    // R10: the strobe never lasts two cycles.
    a_r10_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R8: a break is also a framing error with zero data.
    a_r8_break_is_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && err_break) |-> (err_frame && rx_data == 8'h00));

    // R9: overrun mirrors the full indication at the stop sample.
    a_r9_overrun_track: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (err_overrun == $past(hold_full)));

    // R6: no parity error when parity is off.
    a_r6_no_parity_off: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !par_en) |-> !err_parity);

    // R5: bits above the word length are zero.
    a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> ((rx_data >> (4'd5 + {2'b00, word_len})) == 8'h00));

endmodule

bind uart_rx_deser uart_rx_deser_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold_full  (hold_full),
    .word_len   (word_len),
    .par_en     (par_en),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .err_parity (err_parity),
    .err_frame  (err_frame),
    .err_break  (err_break),
    .err_overrun(err_overrun)
);

// File: tb/uart_rx_deser_tb_top.sv
// Testbench for uart_rx_deser: directed corner cases plus seeded random frames.
module uart_rx_deser_tb_top;

    localparam int TDIV = 3;   // clocks per oversampling tick

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       os_mode_8x = 1'b0;
    logic [1:0] word_len = 2'b11;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       hold_full = 1'b0;
    logic       rx_serial = 1'b1;
    logic       rx_valid;
    logic [7:0] rx_data;
    logic       err_parity, err_frame, err_break, err_overrun;

    int checks = 0;
    int errors = 0;
    int got_n = 0;
    int pulse_bad = 0;
    logic [7:0] got_d [0:255];
    logic [3:0] got_e [0:255];
    logic       prev_valid = 1'b0;

    always #5 clk = ~clk;

    uart_rx_deser dut_i (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .os_mode_8x(os_mode_8x),
        .word_len(word_len), .par_en(par_en), .par_odd(par_odd),
        .hold_full(hold_full), .rx_serial(rx_serial), .rx_valid(rx_valid),
        .rx_data(rx_data), .err_parity(err_parity), .err_frame(err_frame),
        .err_break(err_break), .err_overrun(err_overrun)
    );

    // Oversampling tick: one clock high out of every TDIV.
    initial begin
        int k = 0;
        forever begin
            @(negedge clk);
            os_tick = (k == 0);
            k = (k + 1) % TDIV;
        end
    end

    // Output monitor: capture every strobe, flag stretched strobes (R10).
    initial begin
        forever begin
            @(negedge clk);
            if (rx_valid) begin
                if (prev_valid) pulse_bad++;
                if (got_n < 256) begin
                    got_d[got_n] = rx_data;
                    got_e[got_n] = {err_overrun, err_break, err_frame, err_parity};
                end
                got_n++;
            end
            prev_valid = rx_valid;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mask_of(input logic [1:0] wl);
        return 8'((9'd1 << (5 + wl)) - 9'd1);
    endfunction

    function automatic logic par_bit(input logic [7:0] d, input logic [1:0] wl,
                                     input logic po, input logic flip);
        return (^(d & mask_of(wl))) ^ po ^ flip;
    endfunction

    // Expected flags {overrun, break, frame, parity}.
    function automatic logic [3:0] exp_flags(input logic [7:0] d, input logic [1:0] wl,
                                             input logic pe, input logic po, input logic flip,
                                             input logic stopv, input logic hf);
        logic pb;
        logic brk;
        pb  = par_bit(d, wl, po, flip);
        brk = ((d & mask_of(wl)) == 8'h00) && (!pe || !pb) && !stopv;
        return {hf, brk, !stopv, pe && flip};
    endfunction

    task automatic hold_line(input logic v, input int ticks);
        rx_serial = v;
        repeat (ticks * TDIV) @(negedge clk);
    endtask

    task automatic send_frame(input logic m8, input logic [1:0] wl, input logic pe,
                              input logic po, input logic [7:0] d, input logic flip,
                              input logic stopv, input logic hf, input int idle_bits);
        int bt;
        bt = m8 ? 8 : 16;
        os_mode_8x = m8; word_len = wl; par_en = pe; par_odd = po; hold_full = hf;
        hold_line(1'b0, bt);
        for (int i = 0; i < 5 + wl; i++) hold_line(d[i], bt);
        if (pe) hold_line(par_bit(d, wl, po, flip), bt);
        hold_line(stopv, bt);
        hold_line(1'b1, bt * idle_bits);
    endtask

    task automatic frame_check(input string req, input logic m8, input logic [1:0] wl,
                               input logic pe, input logic po, input logic [7:0] d,
                               input logic flip, input logic stopv, input logic hf);
        int base;
        base = got_n;
        send_frame(m8, wl, pe, po, d, flip, stopv, hf, 2);
        check({req, " count"}, got_n, base + 1);
        if (got_n > base) begin
            check({req, " data"}, got_d[base], d & mask_of(wl));
            check({req, " flags"}, got_e[base], exp_flags(d, wl, pe, po, flip, stopv, hf));
        end
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int base;
        void'($urandom(32'h5eed_1234));
        repeat (5) @(negedge clk);
        // R1: reset state
        check("R1 valid in reset", rx_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 data after reset", rx_data, 0);
        check("R1 flags after reset", {err_overrun, err_break, err_frame, err_parity}, 0);
        check("R1 valid after reset", rx_valid, 0);
        repeat (20) @(negedge clk);

        // R2 / R3: both oversampling modes
        frame_check("R2 16x", 1'b0, 2'b11, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b1, 1'b0);
        frame_check("R3 8x", 1'b1, 2'b11, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b1, 1'b0);

        // R4: false starts in each mode, then a good frame
        base = got_n;
        os_mode_8x = 1'b0; hold_line(1'b0, 3); hold_line(1'b1, 64);
        check("R4 false start 16x", got_n, base);
        os_mode_8x = 1'b1; hold_line(1'b0, 1); hold_line(1'b1, 32);
        check("R4 false start 8x", got_n, base);
        frame_check("R4 after glitch", 1'b1, 2'b11, 1'b0, 1'b0, 8'h96, 1'b0, 1'b1, 1'b0);

        // R5: every word length with all-ones data
        for (int w = 0; w < 4; w++)
            frame_check("R5 word length", 1'b0, 2'(w), 1'b0, 1'b0, 8'hFF, 1'b0, 1'b1, 1'b0);
        frame_check("R5 lsb first", 1'b1, 2'b00, 1'b0, 1'b0, 8'h01, 1'b0, 1'b1, 1'b0);

        // R6: parity even/odd, correct and flipped
        frame_check("R6 even ok", 1'b0, 2'b11, 1'b1, 1'b0, 8'h6B, 1'b0, 1'b1, 1'b0);
        frame_check("R6 even bad", 1'b0, 2'b11, 1'b1, 1'b0, 8'h6B, 1'b1, 1'b1, 1'b0);
        frame_check("R6 odd ok", 1'b1, 2'b10, 1'b1, 1'b1, 8'h55, 1'b0, 1'b1, 1'b0);
        frame_check("R6 odd bad", 1'b1, 2'b10, 1'b1, 1'b1, 8'h55, 1'b1, 1'b1, 1'b0);

        // R7: low stop bit
        frame_check("R7 framing", 1'b0, 2'b11, 1'b0, 1'b0, 8'h5A, 1'b0, 1'b0, 1'b0);

        // R8 / R12: break then line held low
        base = got_n;
        send_frame(1'b0, 2'b11, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 0);
        rx_serial = 1'b0;
        repeat (3 * 11 * 16 * TDIV) @(negedge clk);
        check("R12 no retrigger while low", got_n, base + 1);
        check("R8 break flags", got_e[base], 4'b0110);
        check("R8 break data", got_d[base], 0);
        hold_line(1'b1, 32);

        // R9: overrun follows hold_full
        frame_check("R9 overrun set", 1'b0, 2'b01, 1'b0, 1'b0, 8'h2A, 1'b0, 1'b1, 1'b1);
        frame_check("R9 overrun clear", 1'b1, 2'b01, 1'b0, 1'b0, 8'h15, 1'b0, 1'b1, 1'b0);

        // R11: back-to-back frames with no gap after the stop bit
        base = got_n;
        send_frame(1'b0, 2'b11, 1'b0, 1'b0, 8'h11, 1'b0, 1'b1, 1'b0, 0);
        send_frame(1'b0, 2'b11, 1'b0, 1'b0, 8'h22, 1'b0, 1'b1, 1'b0, 0);
        send_frame(1'b0, 2'b11, 1'b0, 1'b0, 8'hC3, 1'b0, 1'b1, 1'b0, 0);
        send_frame(1'b0, 2'b11, 1'b0, 1'b0, 8'h7E, 1'b0, 1'b1, 1'b0, 2);
        check("R11 burst count", got_n, base + 4);
        check("R11 burst 0", got_d[base], 8'h11);
        check("R11 burst 1", got_d[base + 1], 8'h22);
        check("R11 burst 2", got_d[base + 2], 8'hC3);
        check("R11 burst 3", got_d[base + 3], 8'h7E);

        // Random frames across all settings (R2 R3 R5 R6 R7 R8 R9)
        for (int n = 0; n < 40; n++) begin
            logic m8, pe, po, flip, stopv, hf;
            logic [1:0] wl;
            logic [7:0] d;
            m8 = 1'($urandom); pe = 1'($urandom); po = 1'($urandom);
            wl = 2'($urandom); d = 8'($urandom); hf = 1'($urandom);
            flip  = pe && ($urandom % 4 == 0);
            stopv = ($urandom % 8 != 0);
            if ($urandom % 10 == 0) d = 8'h00;
            frame_check("R2_R3 random", m8, wl, pe, po, d, flip, stopv, hf);
        end

        // R10: no strobe ever lasted more than one cycle
        check("R10 single-cycle strobe", pulse_bad, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule